// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Fetch Control

This block steers instruction fetch in a five-stage in-order pipeline that settles conditional branches in decode. It owns the fetch PC and the valid bit and PC+4 of the fetch-to-decode register. An equality comparator and a target adder sit in decode. Each cycle it picks the next fetch address from three choices: sequential, held or branch target. It also reports whether the instruction now being fetched is thrown away.

The decode logic supplies the operands read for the instruction in decode, its sign-extended byte offset, an is-branch flag and a flag that inverts the compare sense. A parameter sets the branch policy. With `STALL_MODE = 1`, every branch stops fetch for one cycle and then fetches the resolved address. With `STALL_MODE = 0`, fetch continues down the fall-through path. A taken branch then discards the one wrongly fetched instruction.

Top module: `brc_fetch_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the fetch PC reads 0 and the decode-slot valid flag reads 0.
- R2: With no active branch, the fetch PC grows by 4 every cycle. The decode slot then becomes valid and carries the previous fetch PC plus 4.
- R3: An active branch with the inverted-sense flag at 0 is taken exactly when its two operands are equal. Its target is the decode slot's PC+4 plus the signed byte offset, and the target is visible in the same cycle.
- R4: With the inverted-sense flag at 1, the branch is taken exactly when the two operands differ.
- R5: In stall mode every active branch raises the stall output. The decode slot is invalid in the following cycle. A not-taken branch leaves the fetch PC unchanged for that one cycle.
- R6: In stall mode a taken branch loads the target into the fetch PC on the next edge, after exactly one bubble.
- R7: In predict-not-taken mode a not-taken branch costs nothing. There is no squash, the PC advances by 4 and the next decode slot stays valid.
- R8: In predict-not-taken mode a taken branch raises the squash output and loads the target into the fetch PC. The next decode slot is invalid, which gives a one-cycle penalty.
- R9: The branch inputs have no effect while the decode slot is invalid: no redirect, no stall and no squash.
- R10: The next-PC select output uses the encoding 0 for sequential, 1 for hold and 2 for target.
- R11: A negative offset yields a target below the branch's PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| is_branch_i | input | 1 | Instruction in decode is a conditional branch |
| br_ne_i | input | 1 | Branch is taken on inequality instead of equality |
| rs_data_i | input | XLEN | First source operand read in decode |
| rt_data_i | input | XLEN | Second source operand read in decode |
| br_off_i | input | XLEN | Sign-extended byte offset |
| pc_o | output | XLEN | Current fetch address |
| id_valid_o | output | 1 | Decode slot holds a real instruction |
| id_pc4_o | output | XLEN | PC+4 of the instruction in decode |
| npc_sel_o | output | 2 | Next-PC choice: 0 sequential, 1 hold, 2 target |
| br_target_o | output | XLEN | Branch target computed in decode |
| br_taken_o | output | 1 | Active branch resolves taken |
| squash_o | output | 1 | Fetched instruction is discarded (predict-not-taken) |
| stall_o | output | 1 | Fetch is held for a branch (stall mode) |

## Verification
A wrong valid bit in the decode slot shows up at the ports within one cycle. A bubble that is not cleared lets the branch inputs redirect fetch a second time, so the bench checks the PC on the very next edge after a stale slot. A fault in the compare or its inverted sense changes the select code and the target in the same cycle the branch sits in decode. A fault in the PC register or the select mux appears as a wrong fetch address one edge later. Both policies run the same stimulus side by side, so a penalty that is one cycle off shows up as diverging PCs at once.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_HOLD = 2'd1,
    NPC_TGT  = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/brc_resolve.sv
module brc_resolve #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_valid_i,
  input  logic            is_branch_i,
  input  logic            br_ne_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic [XLEN-1:0] off_i,
  input  logic [XLEN-1:0] pc4_i,
  output logic            br_act_o,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  logic ops_eq;

  assign ops_eq   = (rs_i == rt_i);
  assign br_act_o = id_valid_i & is_branch_i;
  assign taken_o  = br_act_o & (ops_eq ^ br_ne_i);
  assign target_o = pc4_i + off_i;

  AST_NE_EQUAL_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_ne_i && (rs_i == rt_i)) |-> !taken_o); // R4
  AST_NO_TAKE_IN_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> !taken_o); // R9
endmodule

// File: rtl/brc_policy.sv
module brc_policy
  import brc_pkg::*;
#(
  parameter bit STALL_MODE = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     br_act_i,
  input  logic     taken_i,
  output npc_sel_e sel_o,
  output logic     squash_o,
  output logic     stall_o
);
  generate
    if (STALL_MODE) begin : g_stall
      always_comb begin
        squash_o = 1'b0;
        stall_o  = br_act_i;
        if (!br_act_i)    sel_o = NPC_SEQ;
        else if (taken_i) sel_o = NPC_TGT;
        else              sel_o = NPC_HOLD;
      end
    end else begin : g_pnt
      always_comb begin
        stall_o  = 1'b0;
        squash_o = br_act_i & taken_i;
        sel_o    = squash_o ? NPC_TGT : NPC_SEQ;
      end
      AST_PNT_NT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (br_act_i && !taken_i) |-> (sel_o == NPC_SEQ)); // R7
    end
  endgenerate

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({squash_o, stall_o})); // R5
endmodule

// File: rtl/brc_fetch_pc.sv
module brc_fetch_pc
  import brc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC   = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  npc_sel_e        sel_i,
  input  logic [XLEN-1:0] target_i,
  input  logic            kill_i,
  output logic [XLEN-1:0] pc_o,
  output logic            id_valid_o,
  output logic [XLEN-1:0] id_pc4_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] pc_q, pc_d, pc_seq;
  logic            idv_q;
  logic [XLEN-1:0] idpc4_q;

  assign pc_seq = pc_q + STEP;

  always_comb begin
    unique case (sel_i)
      NPC_HOLD: pc_d = pc_q;
      NPC_TGT:  pc_d = target_i;
      default:  pc_d = pc_seq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      idv_q   <= 1'b0;
      idpc4_q <= '0;
    end else begin
      pc_q    <= pc_d;
      idv_q   <= ~kill_i;
      idpc4_q <= pc_seq;
    end
  end

  assign pc_o       = pc_q;
  assign id_valid_o = idv_q;
  assign id_pc4_o   = idpc4_q;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == NPC_SEQ) |=> (pc_q == $past(pc_q) + STEP)); // R2
  AST_HOLD_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == NPC_HOLD) |=> $stable(pc_q)); // R5
  AST_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == NPC_TGT) |=> (pc_q == $past(target_i))); // R6
  AST_KILL_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !idv_q); // R8
endmodule

// File: rtl/brc_fetch_ctl.sv
module brc_fetch_ctl
  import brc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter bit              STALL_MODE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            is_branch_i,
  input  logic            br_ne_i,
  input  logic [XLEN-1:0] rs_data_i,
  input  logic [XLEN-1:0] rt_data_i,
  input  logic [XLEN-1:0] br_off_i,
  output logic [XLEN-1:0] pc_o,
  output logic            id_valid_o,
  output logic [XLEN-1:0] id_pc4_o,
  output logic [1:0]      npc_sel_o,
  output logic [XLEN-1:0] br_target_o,
  output logic            br_taken_o,
  output logic            squash_o,
  output logic            stall_o
);
  logic            idv, br_act, taken, squash, stall;
  logic [XLEN-1:0] idpc4, target;
  npc_sel_e        sel;

  brc_resolve #(.XLEN(XLEN)) u_resolve (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_valid_i (idv),
    .is_branch_i(is_branch_i),
    .br_ne_i    (br_ne_i),
    .rs_i       (rs_data_i),
    .rt_i       (rt_data_i),
    .off_i      (br_off_i),
    .pc4_i      (idpc4),
    .br_act_o   (br_act),
    .taken_o    (taken),
    .target_o   (target)
  );

  brc_policy #(.STALL_MODE(STALL_MODE)) u_policy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .br_act_i(br_act),
    .taken_i (taken),
    .sel_o   (sel),
    .squash_o(squash),
    .stall_o (stall)
  );

  brc_fetch_pc #(
    .XLEN      (XLEN),
    .INSN_BYTES(INSN_BYTES),
    .RESET_PC  (RESET_PC)
  ) u_fetch_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .target_i  (target),
    .kill_i    (squash | stall),
    .pc_o      (pc_o),
    .id_valid_o(idv),
    .id_pc4_o  (idpc4)
  );

  assign id_valid_o  = idv;
  assign id_pc4_o    = idpc4;
  assign npc_sel_o   = sel;
  assign br_target_o = target;
  assign br_taken_o  = taken;
  assign squash_o    = squash;
  assign stall_o     = stall;

  AST_STALL_NO_TARGET_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && !taken) |=> (pc_o == $past(pc_o))); // R5
endmodule

// File: tb/tb_brc_fetch_ctl.sv
module tb_brc_fetch_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_br = 1'b0, ne = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, off = '0;

  logic [31:0] pc_w [2];
  logic        v_w [2];
  logic [31:0] pc4_w [2];
  logic [1:0]  sel_w [2];
  logic [31:0] tgt_w [2];
  logic        tk_w [2];
  logic        sq_w [2];
  logic        st_w [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_fetch_ctl #(.STALL_MODE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .is_branch_i(is_br), .br_ne_i(ne),
    .rs_data_i(op_a), .rt_data_i(op_b), .br_off_i(off),
    .pc_o(pc_w[0]), .id_valid_o(v_w[0]), .id_pc4_o(pc4_w[0]), .npc_sel_o(sel_w[0]),
    .br_target_o(tgt_w[0]), .br_taken_o(tk_w[0]), .squash_o(sq_w[0]), .stall_o(st_w[0])
  );

  brc_fetch_ctl #(.STALL_MODE(1'b0)) dut_pnt (
    .clk_i(clk), .rst_ni(rst_n), .is_branch_i(is_br), .br_ne_i(ne),
    .rs_data_i(op_a), .rt_data_i(op_b), .br_off_i(off),
    .pc_o(pc_w[1]), .id_valid_o(v_w[1]), .id_pc4_o(pc4_w[1]), .npc_sel_o(sel_w[1]),
    .br_target_o(tgt_w[1]), .br_taken_o(tk_w[1]), .squash_o(sq_w[1]), .stall_o(st_w[1])
  );

  typedef struct {
    int          cyc;
    int          unit;
    logic [31:0] pc;
    logic        v;
    logic [31:0] pc4;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0, cyc_m = 0;
  logic [31:0] m_pc [2];
  logic        m_v [2];
  logic [31:0] m_pc4 [2];

  function automatic void chk(string req, string what, int unit, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s unit%0d actual=%h expected=%h", req, what, unit, act, exp);
    end
  endfunction

  // monitor: compare registered state against queued expectations
  initial forever begin
    @(posedge clk);
    #1;
    cyc_m++;
    while (sb.size() > 0 && sb[0].cyc == cyc_m) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "pc", e.unit, pc_w[e.unit], e.pc);
      chk(e.req, "id_valid", e.unit, 32'(v_w[e.unit]), 32'(e.v));
      if (e.v) chk(e.req, "id_pc4", e.unit, pc4_w[e.unit], e.pc4);
    end
  end

  // driver: call just after a negedge; drives, checks decode outputs, queues next state
  task automatic step(input logic br, input logic inv, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] o, input string req);
    is_br = br; ne = inv; op_a = a; op_b = b; off = o;
    #1;
    for (int u = 0; u < 2; u++) begin
      logic        act, tk;
      logic [31:0] tgt, npc;
      logic [1:0]  esel;
      act = br && m_v[u];
      tk  = act && ((a == b) != inv);
      tgt = m_pc4[u] + o;
      if (u == 0) esel = act ? (tk ? 2'd2 : 2'd1) : 2'd0;
      else        esel = tk ? 2'd2 : 2'd0;
      chk(req, "npc_sel", u, 32'(sel_w[u]), 32'(esel));
      chk(req, "taken", u, 32'(tk_w[u]), 32'(tk));
      chk(req, "stall", u, 32'(st_w[u]), 32'((u == 0) && act));
      chk(req, "squash", u, 32'(sq_w[u]), 32'((u == 1) && tk));
      if (act) chk(req, "target", u, tgt_w[u], tgt);
      npc = (esel == 2'd2) ? tgt : (esel == 2'd1) ? m_pc[u] : m_pc[u] + 32'd4;
      m_pc4[u] = m_pc[u] + 32'd4;
      m_v[u]   = !((u == 0) ? act : tk);
      m_pc[u]  = npc;
      sb.push_back('{cyc_m + 1, u, m_pc[u], m_v[u], m_pc4[u], req});
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk("R1", "pc_in_reset", u, pc_w[u], 32'd0);
      chk("R1", "valid_in_reset", u, 32'(v_w[u]), 32'd0);
    end
    rst_n = 1'b1;
    #1;
    for (int u = 0; u < 2; u++) begin
      chk("R1", "pc_after_reset", u, pc_w[u], 32'd0);
      chk("R1", "valid_after_reset", u, 32'(v_w[u]), 32'd0);
      m_pc[u] = '0; m_v[u] = 1'b0; m_pc4[u] = '0;
    end
    // R9: branch request while decode slot is still empty after reset
    step(1'b1, 1'b0, 32'd5, 32'd5, 32'd64, "R9");
    // R2 sequential flow
    repeat (3) step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R2");
    // R3 R6 R8 equal-compare taken, positive offset
    step(1'b1, 1'b0, 32'hA5, 32'hA5, 32'd32, "R3_R6_R8");
    repeat (2) step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R2");
    // R5 R7 equal-compare not taken
    step(1'b1, 1'b0, 32'd1, 32'd2, 32'd100, "R5_R7");
    // R9 stall-mode slot is a bubble here; predict-not-taken slot is live
    step(1'b1, 1'b0, 32'd7, 32'd7, 32'd8, "R9");
    repeat (2) step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R10");
    // R4 inverted sense with equal operands: not taken
    step(1'b1, 1'b1, 32'd9, 32'd9, 32'd12, "R4");
    step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R2");
    // R4 R11 inverted sense with differing operands, negative offset
    step(1'b1, 1'b1, 32'd3, 32'd4, 32'hFFFF_FFF0, "R4_R11");
    repeat (3) step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R2");
    // back-to-back requests: second one lands on a bubble in both modes
    step(1'b1, 1'b0, 32'd0, 32'd0, 32'd40, "R6_R8");
    step(1'b1, 1'b0, 32'd0, 32'd0, 32'd40, "R9");
    repeat (3) step(1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "R2");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule